// File: doc/BRIEF.md
# Four-Channel Waveform Sample Capture with Ready Interrupt

This block sits at the end of a current-measurement datapath. It takes the most recent filtered samples of the three phase currents and the neutral current. These samples arrive on a stream at a fixed 8 kHz rate, after high-pass filtering. On each sample beat the block copies all four values into 24-bit signed waveform registers at the same clock edge. Software therefore never sees a mix of two beats. At that edge it also raises a ready flag in a status word.

The sample stream uses valid/ready. The block keeps `smp_ready` high at all times and never applies back-pressure, so the upstream filter chain and the other calculations that share it are never stalled. A beat is accepted in every cycle where `smp_valid` is high. A register port lets software read the waveforms, the status word and the mask word. Each waveform is returned sign-extended to 32 bits. Writing a 1 to the ready bit clears it. When the ready flag and its mask bit are both set, an active-low interrupt line is driven low.

Address map (3-bit word address):

| Address | Register |
|---|---|
| 0 | phase A waveform |
| 1 | phase B waveform |
| 2 | phase C waveform |
| 3 | neutral waveform |
| 4 | status |
| 5 | mask |
| 6, 7 | unmapped |

Top module: `wave_capture`

## Requirements
- R1: After reset, every waveform register, the status word and the mask word read as 0. In the same state `irq_n` is 1 and `rd_valid` is 0.
- R2: A cycle with `smp_valid` high loads all four waveform registers at the same edge. The loaded values are the 24-bit lanes of `smp_data`: bits [23:0] go to phase A, [47:24] to phase B, [71:48] to phase C and [95:72] to neutral.
- R3: When `smp_valid` is low, the waveform registers keep their values.
- R4: A read of addresses 0 to 3 returns the 24-bit value in bits [23:0]. Bits [31:24] are each a copy of bit 23.
- R5: An accepted beat sets status bit 17, the ready flag. All other status bits always read 0.
- R6: A write to address 4 with data bit 17 at 1 clears the ready flag. A write there with bit 17 at 0 leaves the flag unchanged.
- R7: If a beat is accepted in the same cycle as a clearing write, the ready flag stays set.
- R8: Address 5 holds a 32-bit mask that can be written and read back. `irq_n` is 0 exactly when some bit is 1 in both the status word and the mask.
- R9: `smp_ready` is 1 in every cycle, so the sample stream is never stalled.
- R10: Writes to addresses 0 to 3 and 6 to 7 have no effect. Reads of addresses 6 and 7 return 0.
- R11: A read issued with `rd_en` returns `rd_valid`=1 and its data one cycle later. If a beat arrives in the same cycle as the read, the read returns the values from before that beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| smp_valid | input | 1 | sample beat present |
| smp_ready | output | 1 | always 1, beat accepted |
| smp_data | input | 96 | four 24-bit samples, phase A in the low lane |
| rd_en | input | 1 | read request |
| rd_addr | input | 3 | read word address |
| rd_valid | output | 1 | read data present |
| rd_data | output | 32 | read data |
| wr_en | input | 1 | write request |
| wr_addr | input | 3 | write word address |
| wr_data | input | 32 | write data |
| irq_n | output | 1 | active-low interrupt |

## Verification
Loads of the waveform registers and changes to the ready flag take effect at the edge that accepts the beat or the write. `irq_n` follows in the same cycle, because it is combinational on the flag and mask registers. Read data arrives on the edge after `rd_en` and reflects the register state from before that edge.

The bench drives every input one nanosecond after a rising edge and holds it for one edge. It then samples one nanosecond after that edge. It compares the samples against a model that is updated only after the expected read value has been taken from the state before the edge, so same-cycle corners get the pre-edge result.

// File: rtl/wcap_pkg.sv
package wcap_pkg;
  localparam int unsigned WCAP_CH_N   = 4;
  localparam int unsigned WCAP_SMP_W  = 24;
  localparam int unsigned WCAP_WORD_W = 32;
  localparam int unsigned WCAP_ADDR_W = 3;
  localparam int unsigned WCAP_RDY_BIT = 17;
  localparam int unsigned WCAP_ADDR_STATUS = 4;
  localparam int unsigned WCAP_ADDR_MASK   = 5;
endpackage

// File: rtl/wcap_sample_bank.sv
module wcap_sample_bank #(
  parameter int unsigned CH_N  = 4,
  parameter int unsigned SMP_W = 24
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load,
  input  logic [CH_N*SMP_W-1:0]       din,
  output logic [CH_N-1:0][SMP_W-1:0]  wave
);
  genvar ch;
  generate
    for (ch = 0; ch < CH_N; ch++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          wave[ch] <= '0;
        else if (load)
          wave[ch] <= din[ch*SMP_W +: SMP_W];
      end
    end
  endgenerate

  // R2
  lanes_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (wave == $past(din)));
  // R3
  lanes_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(wave));
endmodule

// File: rtl/wcap_status.sv
module wcap_status #(
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned RDY_BIT = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_evt,
  input  logic              wr_status,
  input  logic              wr_mask,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] status_q,
  output logic [WORD_W-1:0] mask_q,
  output logic              irq_n
);
  logic ready_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ready_q <= 1'b0;
    else if (set_evt)
      ready_q <= 1'b1;
    else if (wr_status && wr_data[RDY_BIT])
      ready_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mask_q <= '0;
    else if (wr_mask)
      mask_q <= wr_data;
  end

  always_comb begin
    status_q = '0;
    status_q[RDY_BIT] = ready_q;
  end

  assign irq_n = ~|(status_q & mask_q);

  // R5
  rdy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> status_q[RDY_BIT]);
  // R6
  rdy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_status && wr_data[RDY_BIT] && !set_evt) |=> !status_q[RDY_BIT]);
  // R6
  rdy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_evt && !(wr_status && wr_data[RDY_BIT])) |=> $stable(status_q));
  // R8
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (status_q[RDY_BIT] && mask_q[RDY_BIT]));
  // R5
  status_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(status_q) <= 1);
endmodule

// File: rtl/wcap_readout.sv
module wcap_readout #(
  parameter int unsigned CH_N        = 4,
  parameter int unsigned SMP_W       = 24,
  parameter int unsigned WORD_W      = 32,
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned ADDR_STATUS = 4,
  parameter int unsigned ADDR_MASK   = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rd_en,
  input  logic [ADDR_W-1:0]           rd_addr,
  input  logic [CH_N-1:0][SMP_W-1:0]  wave,
  input  logic [WORD_W-1:0]           status_q,
  input  logic [WORD_W-1:0]           mask_q,
  output logic                        rd_valid,
  output logic [WORD_W-1:0]           rd_data
);
  localparam int unsigned EXT_W = WORD_W - SMP_W;

  logic [WORD_W-1:0] sel_word;

  always_comb begin
    sel_word = '0;
    for (int c = 0; c < CH_N; c++) begin
      if (rd_addr == ADDR_W'(c))
        sel_word = {{EXT_W{wave[c][SMP_W-1]}}, wave[c]};
    end
    if (rd_addr == ADDR_W'(ADDR_STATUS))
      sel_word = status_q;
    if (rd_addr == ADDR_W'(ADDR_MASK))
      sel_word = mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en)
        rd_data <= sel_word;
    end
  end

  // R11
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  // R11
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
  // R4
  rd_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr < ADDR_W'(CH_N)) |=>
      (rd_data[WORD_W-1:SMP_W] == {EXT_W{rd_data[SMP_W-1]}}));
endmodule

// File: rtl/wave_capture.sv
module wave_capture
  import wcap_pkg::*;
#(
  parameter int unsigned CH_N    = WCAP_CH_N,
  parameter int unsigned SMP_W   = WCAP_SMP_W,
  parameter int unsigned WORD_W  = WCAP_WORD_W,
  parameter int unsigned ADDR_W  = WCAP_ADDR_W,
  parameter int unsigned RDY_BIT = WCAP_RDY_BIT
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_valid,
  output logic                    smp_ready,
  input  logic [CH_N*SMP_W-1:0]   smp_data,
  input  logic                    rd_en,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic                    rd_valid,
  output logic [WORD_W-1:0]       rd_data,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [WORD_W-1:0]       wr_data,
  output logic                    irq_n
);
  logic                       beat;
  logic                       wr_status;
  logic                       wr_mask;
  logic [CH_N-1:0][SMP_W-1:0] wave;
  logic [WORD_W-1:0]          status_q;
  logic [WORD_W-1:0]          mask_q;

  assign smp_ready = 1'b1;
  assign beat      = smp_valid && smp_ready;
  assign wr_status = wr_en && (wr_addr == ADDR_W'(WCAP_ADDR_STATUS));
  assign wr_mask   = wr_en && (wr_addr == ADDR_W'(WCAP_ADDR_MASK));

  wcap_sample_bank #(.CH_N(CH_N), .SMP_W(SMP_W)) u_bank (
    .clk  (clk),
    .rst_n(rst_n),
    .load (beat),
    .din  (smp_data),
    .wave (wave)
  );

  wcap_status #(.WORD_W(WORD_W), .RDY_BIT(RDY_BIT)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_evt  (beat),
    .wr_status(wr_status),
    .wr_mask  (wr_mask),
    .wr_data  (wr_data),
    .status_q (status_q),
    .mask_q   (mask_q),
    .irq_n    (irq_n)
  );

  wcap_readout #(
    .CH_N(CH_N), .SMP_W(SMP_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W),
    .ADDR_STATUS(WCAP_ADDR_STATUS), .ADDR_MASK(WCAP_ADDR_MASK)
  ) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .wave    (wave),
    .status_q(status_q),
    .mask_q  (mask_q),
    .rd_valid(rd_valid),
    .rd_data (rd_data)
  );

  // R7
  rdy_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && wr_status && wr_data[RDY_BIT]) |=> !irq_n || !mask_q[RDY_BIT]);
  // R8
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> irq_n);
endmodule

// File: tb/wave_capture_test.sv
module wave_capture_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [95:0] smp_data = '0;
  logic        rd_en = 1'b0;
  logic [2:0]  rd_addr = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        irq_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [23:0] m_wave [4];
  logic        m_rdy;
  logic [31:0] m_mask;

  always #2.5 clk = ~clk;

  wave_capture uut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid),
    .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .irq_n(irq_n)
  );

  function automatic logic [31:0] sext(input logic [23:0] v);
    return {{8{v[23]}}, v};
  endfunction

  function automatic logic [31:0] exp_read(input logic [2:0] a);
    if (a < 3'd4) return sext(m_wave[a]);
    if (a == 3'd4) return {14'd0, m_rdy, 17'd0};
    if (a == 3'd5) return m_mask;
    return 32'd0;
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One edge with the given stimulus, then check read data, ready and irq.
  task automatic step(input bit do_tick, input logic [95:0] tdata,
                      input bit do_rd, input logic [2:0] raddr,
                      input bit do_wr, input logic [2:0] waddr,
                      input logic [31:0] wdata, input string tag);
    logic [31:0] exp_rd;
    smp_valid = do_tick; smp_data = tdata;
    rd_en = do_rd; rd_addr = raddr;
    wr_en = do_wr; wr_addr = waddr; wr_data = wdata;
    exp_rd = exp_read(raddr);
    @(posedge clk);
    #1;
    smp_valid = 1'b0; rd_en = 1'b0; wr_en = 1'b0;
    if (do_tick) begin
      for (int c = 0; c < 4; c++) m_wave[c] = tdata[c*24 +: 24];
      m_rdy = 1'b1;
    end else if (do_wr && waddr == 3'd4 && wdata[17]) begin
      m_rdy = 1'b0;
    end
    if (do_wr && waddr == 3'd5) m_mask = wdata;
    chk(rd_valid == do_rd, {tag, " R11 rd_valid"}, 32'(rd_valid), 32'(do_rd));
    if (do_rd) chk(rd_data == exp_rd, {tag, " rd_data"}, rd_data, exp_rd);
    chk(irq_n == !(m_rdy && m_mask[17]), {tag, " R8 irq_n"},
        32'(irq_n), 32'(!(m_rdy && m_mask[17])));
    chk(smp_ready == 1'b1, {tag, " R9 smp_ready"}, 32'(smp_ready), 32'd1);
  endtask

  task automatic rd(input logic [2:0] a, input string tag);
    step(1'b0, '0, 1'b1, a, 1'b0, 3'd0, 32'd0, tag);
  endtask

  initial begin
    logic [31:0] junk;
    junk = $urandom(32'd4242);
    for (int c = 0; c < 4; c++) m_wave[c] = '0;
    m_rdy = 1'b0; m_mask = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    chk(irq_n == 1'b1, "R1 irq_n", 32'(irq_n), 32'd1);
    chk(rd_valid == 1'b0, "R1 rd_valid", 32'(rd_valid), 32'd0);
    for (int a = 0; a < 8; a++) rd(3'(a), "R1 reset read");
    // R2 R4 negative and positive extremes
    step(1'b1, {24'h123456, 24'h000001, 24'h7FFFFF, 24'h800000},
         1'b0, 3'd0, 1'b0, 3'd0, 32'd0, "R2 tick");
    rd(3'd0, "R4 neg sext");
    rd(3'd1, "R4 pos max");
    rd(3'd2, "R2 lane C");
    rd(3'd3, "R2 lane N");
    rd(3'd4, "R5 status set");
    // R3 hold over idle cycles
    repeat (3) step(1'b0, 96'hFFFF, 1'b0, 3'd0, 1'b0, 3'd0, 32'd0, "R3 idle");
    rd(3'd0, "R3 hold");
    // R8 mask
    step(1'b0, '0, 1'b0, 3'd0, 1'b1, 3'd5, 32'hA5A20000, "R8 mask write");
    rd(3'd5, "R8 mask readback");
    // R6 write 0 keeps, write 1 clears
    step(1'b0, '0, 1'b0, 3'd0, 1'b1, 3'd4, 32'hFFFDFFFF, "R6 w0 keep");
    rd(3'd4, "R6 keep read");
    step(1'b0, '0, 1'b0, 3'd0, 1'b1, 3'd4, 32'h00020000, "R6 w1 clear");
    rd(3'd4, "R6 cleared read");
    // R7 tick beats clear
    step(1'b1, {4{24'hABCDEF}}, 1'b0, 3'd0, 1'b1, 3'd4, 32'hFFFFFFFF, "R7 tick+clear");
    rd(3'd4, "R7 still set");
    // R10 ignored writes and unmapped reads
    step(1'b0, '0, 1'b0, 3'd0, 1'b1, 3'd1, 32'h00000000, "R10 wave write");
    rd(3'd1, "R10 wave unchanged");
    step(1'b0, '0, 1'b0, 3'd0, 1'b1, 3'd6, 32'hFFFFFFFF, "R10 unmapped write");
    rd(3'd6, "R10 unmapped read");
    rd(3'd7, "R10 unmapped read 7");
    // R11 read in the same cycle as a tick returns old data
    step(1'b1, {24'h0, 24'h0, 24'h0, 24'h111111}, 1'b1, 3'd0,
         1'b0, 3'd0, 32'd0, "R11 read during tick");
    rd(3'd0, "R11 after tick");
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [95:0] d;
      logic [31:0] w;
      logic [3:0]  op;
      d = {$urandom, $urandom, $urandom};
      w = $urandom;
      op = 4'($urandom % 16);
      if (op[0]) w[17] = 1'b1;
      step(op[1], d, op[2], 3'($urandom % 8), op[3],
           3'(3 + $urandom % 4), w, "R2 R4 R6 R7 random");
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule